// File: doc/BRIEF.md
# Echo-Handshake Launch Sequencer

This block sits at the receiving end of a 32-bit word channel that another processor uses to bring a secondary core out of reset. It takes one word at a time from the incoming channel and returns each word unchanged on a return channel. It compares each word with the step of a fixed six-word launch command. The command starts with the header 0, 0, 1 and ends with three payload words: the vector-table base, the initial stack pointer and the entry address. Any header word that does not match sends the sequencer back to the first step. The sender can therefore resynchronise at any time by starting over.

The controller has five states. `ST_RECV` waits for an incoming word and consumes it. `ST_ECHO` tries to return the word. `ST_DOZE` sleeps while the return channel is full. `ST_FIRE` emits the launch pulse. `ST_HALT` holds the captured payload. The transitions are:
- RECV to ECHO on a consumed word.
- ECHO to RECV when the echo is pushed and the command is not complete.
- ECHO to FIRE when the echo of the sixth word is pushed.
- ECHO to DOZE when the return channel has no space.
- DOZE to ECHO on a wake event.
- FIRE to HALT unconditionally.
- HALT to HALT.

Top module: `echo_launch_seq`

## Requirements
- R1: While reset is high, `rx_pop`, `ret_push` and `launch_go` stay low. After reset the step is 0 and the three payload outputs read 0.
- R2: Every word consumed (`rx_pop` high at a clock edge while `rx_valid` is high) is returned once, unchanged, on `ret_data` with `ret_push`, in the order received.
- R3: After a word is consumed, no further word is consumed until its echo has been pushed.
- R4: Steps 0, 1 and 2 accept only the values 0, 0 and 1. Any other value at those steps returns the sequencer to step 0. No payload is captured and no launch occurs unless the full header is seen in order.
- R5: A non-matching word received at step 0 is still echoed, and the sequencer stays at step 0.
- R6: Steps 3, 4 and 5 accept any value, including 0 and 1. The words at those steps drive `vtor_addr`, `stack_ptr` and `entry_pc` respectively.
- R7: `launch_go` is high for exactly one cycle, in the cycle right after the echo of the sixth word is pushed.
- R8: After launch no further word is consumed or echoed, and the payload outputs hold their values until reset.
- R9: If the return channel has no space when an echo is due, the sequencer sleeps. It retries only on a `wake_evt` pulse. Space becoming free without an event produces no push. An event while space is still absent keeps it asleep.
- R10: A word whose echo was delayed by sleeping is processed with the step it arrived in, so the sequence resumes correctly after the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Incoming channel holds a word |
| rx_data | input | 32 | Head word of the incoming channel |
| rx_pop | output | 1 | Consume the head word at this edge |
| ret_space | input | 1 | Return channel can accept a word |
| ret_push | output | 1 | Write `ret_data` into the return channel at this edge |
| ret_data | output | 32 | Echoed word |
| wake_evt | input | 1 | Event pulse that ends a sleep |
| launch_go | output | 1 | One-cycle launch pulse |
| vtor_addr | output | 32 | Captured vector-table base |
| stack_ptr | output | 32 | Captured initial stack pointer |
| entry_pc | output | 32 | Captured entry address |

## Verification
The hardest situation to reach is a sleep in the middle of a command, where return space comes back before any wake event arrives. The bench holds `ret_space` low and sends a header word, then pulses `wake_evt` while space is still absent. It then raises space and waits without an event, and only after that pulses the event. After the wake it completes the command, which shows that the delayed word kept its step. Header-breaking patterns such as 0, 0, 0, 1 are also driven, where the repeated zero must not count towards a new header.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    localparam int HDR_WORDS = 3;
    localparam int PAY_WORDS = 3;
    localparam int SEQ_WORDS = HDR_WORDS + PAY_WORDS;
    localparam int STEP_W    = $clog2(SEQ_WORDS);

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [2:0] {
        ST_RECV,
        ST_ECHO,
        ST_DOZE,
        ST_FIRE,
        ST_HALT
    } seq_state_t;

    // Header literal for a header step: zeros, then a single one on the last header step.
    function automatic logic hdr_bit(input step_t s);
        return (s == step_t'(HDR_WORDS - 1));
    endfunction
endpackage

// File: rtl/lsq_step_check.sv
module lsq_step_check
    import lsq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  step_t             step,
    input  logic [DATA_W-1:0] word,
    output step_t             step_next,
    output logic              seq_last
);
    logic              in_hdr;
    logic [DATA_W-1:0] hdr_expect;
    logic              word_ok;

    always_comb begin
        in_hdr     = (step < step_t'(HDR_WORDS));
        hdr_expect = {{(DATA_W-1){1'b0}}, hdr_bit(step)};
        word_ok    = !in_hdr || (word == hdr_expect);
        seq_last   = (step == step_t'(SEQ_WORDS - 1));
        if (!word_ok || seq_last) begin
            step_next = '0;
        end else begin
            step_next = step + step_t'(1);
        end
    end
endmodule

// File: rtl/lsq_payload_regs.sv
module lsq_payload_regs
    import lsq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              consume,
    input  step_t                             step,
    input  logic [DATA_W-1:0]                 word,
    output logic [PAY_WORDS-1:0][DATA_W-1:0]  slots
);
    for (genvar g = 0; g < PAY_WORDS; g++) begin : g_slot
        localparam step_t SLOT_STEP = step_t'(HDR_WORDS + g);
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (consume && (step == SLOT_STEP)) begin
                slots[g] <= word;
            end
        end
    end
endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
    import lsq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_pop,
    input  logic              ret_space,
    output logic              ret_push,
    output logic [DATA_W-1:0] ret_data,
    input  logic              wake_evt,
    input  step_t             step_next,
    input  logic              seq_last,
    output step_t             step_q,
    output logic              launch_go,
    output logic              halted
);
    seq_state_t        state_q, state_d;
    step_t             nxt_q;
    logic              last_q;
    logic [DATA_W-1:0] echo_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RECV;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECV: if (rx_valid) state_d = ST_ECHO;
            ST_ECHO: begin
                if (!ret_space)  state_d = ST_DOZE;
                else if (last_q) state_d = ST_FIRE;
                else             state_d = ST_RECV;
            end
            ST_DOZE: if (wake_evt) state_d = ST_ECHO;
            ST_FIRE: state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RECV;
        endcase
    end

    // Outputs
    always_comb begin
        rx_pop    = (state_q == ST_RECV) && rx_valid && !rst;
        ret_push  = (state_q == ST_ECHO) && ret_space && !rst;
        ret_data  = echo_q;
        launch_go = (state_q == ST_FIRE);
        halted    = (state_q == ST_HALT);
    end

    // Word, pending step and step register
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            nxt_q  <= '0;
            last_q <= 1'b0;
            echo_q <= '0;
        end else begin
            if (rx_pop) begin
                echo_q <= rx_data;
                nxt_q  <= step_next;
                last_q <= seq_last;
            end
            if (ret_push) begin
                step_q <= nxt_q;
            end
        end
    end

    p_consume_gap_r3: assert property (@(posedge clk) disable iff (rst)
        rx_pop |=> !rx_pop);
    p_echo_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DOZE) |=> $stable(ret_data));
    p_go_single_r7: assert property (@(posedge clk) disable iff (rst)
        launch_go |=> !launch_go);
    p_go_after_echo_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(launch_go) |-> $past(ret_push));
    p_doze_no_push_r9: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_DOZE) && !wake_evt) |=> !ret_push);
endmodule

// File: rtl/echo_launch_seq.sv
module echo_launch_seq
    import lsq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_pop,
    input  logic              ret_space,
    output logic              ret_push,
    output logic [DATA_W-1:0] ret_data,
    input  logic              wake_evt,
    output logic              launch_go,
    output logic [DATA_W-1:0] vtor_addr,
    output logic [DATA_W-1:0] stack_ptr,
    output logic [DATA_W-1:0] entry_pc
);
    step_t                            step_q, step_next;
    logic                             seq_last;
    logic                             halted;
    logic [PAY_WORDS-1:0][DATA_W-1:0] slots;

    lsq_step_check #(.DATA_W(DATA_W)) u_check (
        .step      (step_q),
        .word      (rx_data),
        .step_next (step_next),
        .seq_last  (seq_last)
    );

    lsq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_pop    (rx_pop),
        .ret_space (ret_space),
        .ret_push  (ret_push),
        .ret_data  (ret_data),
        .wake_evt  (wake_evt),
        .step_next (step_next),
        .seq_last  (seq_last),
        .step_q    (step_q),
        .launch_go (launch_go),
        .halted    (halted)
    );

    lsq_payload_regs #(.DATA_W(DATA_W)) u_payload (
        .clk     (clk),
        .rst     (rst),
        .consume (rx_pop),
        .step    (step_q),
        .word    (rx_data),
        .slots   (slots)
    );

    assign vtor_addr = slots[0];
    assign stack_ptr = slots[1];
    assign entry_pc  = slots[2];

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(vtor_addr) && $stable(stack_ptr) && $stable(entry_pc)
                    && !rx_pop && !ret_push));
endmodule

// File: tb/echo_launch_seq_tb.sv
`timescale 1ns/1ps
module echo_launch_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_pop;
    logic        ret_space = 1'b1;
    logic        ret_push;
    logic [31:0] ret_data;
    logic        wake_evt = 1'b0;
    logic        launch_go;
    logic [31:0] vtor_addr, stack_ptr, entry_pc;

    int checks = 0;
    int errors = 0;
    int push_cnt = 0;
    int go_cnt = 0;
    int outstanding = 0;
    int cycles = 0;
    bit prev_push = 1'b0;

    logic [31:0] txq[$];
    logic [31:0] expq[$];

    always #2.5 clk = ~clk;

    echo_launch_seq u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .ret_space(ret_space), .ret_push(ret_push), .ret_data(ret_data),
        .wake_evt(wake_evt), .launch_go(launch_go),
        .vtor_addr(vtor_addr), .stack_ptr(stack_ptr), .entry_pc(entry_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Driver: present the queue head on the negative edge
    always @(negedge clk) begin
        rx_valid = (txq.size() != 0);
        rx_data  = (txq.size() != 0) ? txq[0] : '0;
    end

    // Monitor / scoreboard
    always @(posedge clk) begin
        cycles++;
        if (!rst) begin
            if (ret_push) begin
                push_cnt++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected echo", ret_data, '0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk(ret_data == e, "R2", "echo word", ret_data, e);
                end
                outstanding--;
            end
            if (rx_pop) begin
                chk(outstanding == 0, "R3", "pop with echo pending", outstanding, 0);
                if (txq.size() != 0) void'(txq.pop_front());
                outstanding++;
            end
            if (launch_go) begin
                go_cnt++;
                chk(prev_push, "R7", "go not right after final echo", {31'd0, prev_push}, 1);
            end
            prev_push = ret_push;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000) begin
            chk(1'b0, "WDG", "watchdog expired", cycles, 100000);
            finish_run();
        end
    end

    task automatic send(input logic [31:0] w);
        txq.push_back(w);
        expq.push_back(w);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        txq.delete();
        expq.delete();
        txq.push_back(32'h5555_5555);
        @(negedge clk); #1;
        chk(!rx_pop && !ret_push && !launch_go, "R1", "activity in reset",
            {29'd0, rx_pop, ret_push, launch_go}, 0);
        txq.delete();
        repeat (2) @(negedge clk);
        outstanding = 0; go_cnt = 0; push_cnt = 0; prev_push = 0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((txq.size() != 0 || expq.size() != 0 || outstanding != 0) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 2000, "R2", "drain timeout", n, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_payload(input string req, input logic [31:0] v,
                               input logic [31:0] s, input logic [31:0] p);
        chk(vtor_addr == v, req, "vtor_addr", vtor_addr, v);
        chk(stack_ptr == s, req, "stack_ptr", stack_ptr, s);
        chk(entry_pc == p, req, "entry_pc", entry_pc, p);
    endtask

    initial begin
        int pc0;
        // R1: reset state
        do_reset();
        chk(!launch_go, "R1", "go after reset", {31'd0, launch_go}, 0);
        chk_payload("R1", 0, 0, 0);

        // R2 R6 R7: clean command
        send(0); send(0); send(1);
        send(32'h1000_0100); send(32'h2004_2000); send(32'h1000_0235);
        wait_idle();
        chk(go_cnt == 1, "R7", "go pulse count", go_cnt, 1);
        chk_payload("R6", 32'h1000_0100, 32'h2004_2000, 32'h1000_0235);

        // R8: nothing consumed after launch
        pc0 = push_cnt;
        txq.push_back(32'hDEAD_BEEF);
        repeat (20) @(negedge clk);
        chk(txq.size() == 1, "R8", "word consumed after launch", txq.size(), 1);
        chk(push_cnt == pc0, "R8", "echo after launch", push_cnt, pc0);
        chk_payload("R8", 32'h1000_0100, 32'h2004_2000, 32'h1000_0235);

        // R5 R4: junk at step 0, broken header, then recovery
        do_reset();
        send(7); send(0); send(0); send(5);
        send(0); send(0); send(1);
        send(32'hAAAA_0001); send(32'hBBBB_0002); send(32'hCCCC_0003);
        wait_idle();
        chk(go_cnt == 1, "R5", "launch after resync", go_cnt, 1);
        chk_payload("R4", 32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003);

        // R4: 0,0,0,1 must not be taken as a header
        do_reset();
        send(0); send(0); send(0); send(1);
        send(32'h11); send(32'h22); send(32'h33);
        wait_idle();
        chk(go_cnt == 0, "R4", "launch on broken header", go_cnt, 0);
        chk_payload("R4", 0, 0, 0);
        // R6: payload values 0 and 1 accepted
        send(0); send(0); send(1);
        send(32'h0); send(32'h1); send(32'hFFFF_FFFF);
        wait_idle();
        chk(go_cnt == 1, "R6", "launch with 0/1 payload", go_cnt, 1);
        chk_payload("R6", 32'h0, 32'h1, 32'hFFFF_FFFF);

        // R9 R10: sleep on full return channel
        do_reset();
        ret_space = 1'b0;
        send(0);
        repeat (10) @(negedge clk);
        chk(txq.size() == 0, "R9", "word not consumed", txq.size(), 0);
        chk(push_cnt == 0, "R9", "push without space", push_cnt, 0);
        wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
        repeat (5) @(negedge clk);
        chk(push_cnt == 0, "R9", "push on wake without space", push_cnt, 0);
        ret_space = 1'b1;
        repeat (10) @(negedge clk);
        chk(push_cnt == 0, "R9", "push without wake", push_cnt, 0);
        wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
        repeat (5) @(negedge clk);
        chk(push_cnt == 1, "R9", "push after wake", push_cnt, 1);
        send(0); send(1);
        send(32'h0800_0000); send(32'h2000_1000); send(32'h0800_00C1);
        wait_idle();
        chk(go_cnt == 1, "R10", "launch after sleep", go_cnt, 1);
        chk_payload("R10", 32'h0800_0000, 32'h2000_1000, 32'h0800_00C1);

        finish_run();
    end
endmodule